// File: doc/BRIEF.md
# Lane-Partitioned Wide Integer Adder

This block adds two 256-bit integer operands in one clock, but the carry chain is split into 32 byte segments whose links can be cut at run time. A two-bit lane-size control decides where the cuts fall. The one wide operation can then act as thirty-two 8-bit adders, sixteen 16-bit adders, eight 32-bit adders or four 64-bit adders. No carry ever leaves one element and enters the next.

A subtract control turns every lane into a two's-complement subtractor. Operand B is inverted, and a carry of one enters the lowest byte of every lane. Each byte segment has one flag bit in the carry output. Only the flag of a lane's top byte carries that lane's carry-out, and all other flags read zero. The result and flags are captured in a register, so they appear one cycle after the request. An output valid strobe follows the input valid strobe.

Top module: `simd_part_adder`

## Requirements
- R1: With lane_sel = 2'b00, out_sum byte k (bits 8k+7:8k) equals (in_a byte k + in_b byte k) mod 256 for all 32 bytes, with no carry passing between bytes.
- R2: With lane_sel = 2'b01, each of the 16 halfwords (bits 16j+15:16j) of out_sum is the mod-2^16 sum of the matching input halfwords.
- R3: With lane_sel = 2'b10, each of the 8 words (bits 32j+31:32j) of out_sum is the mod-2^32 sum of the matching input words.
- R4: With lane_sel = 2'b11, each of the 4 doublewords (bits 64j+63:64j) of out_sum is the mod-2^64 sum of the matching input doublewords.
- R5: The lane-size encoding is 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits, and lane j always covers the bytes starting at byte j times the lane width in bytes.
- R6: With sub_en = 1, each lane computes A + ~B + 1 in its own width, which gives A - B modulo 2^width.
- R7: out_carry bit k belongs to byte k. For the top byte of each lane it holds the carry out of that lane's full-width sum, where for subtraction a value of 1 means no borrow. Every other out_carry bit is 0.
- R8: A request with in_valid = 1 at a rising edge gives out_valid = 1 and its result after that edge. out_valid is 0 after any edge where in_valid was 0.
- R9: While in_valid is 0, out_sum and out_carry keep the values of the last request.
- R10: Synchronous active-high reset clears out_valid, out_sum and out_carry to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_a | input | 256 | Operand A |
| in_b | input | 256 | Operand B |
| lane_sel | input | 2 | Lane size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| sub_en | input | 1 | 1 = per-lane subtraction A - B |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_sum | output | 256 | Per-lane sums or differences |
| out_carry | output | 32 | Per-byte carry flags, set only on lane top bytes |

## Verification
The adder is tried with all-ones plus one in every lane size. This carry ripples through every byte, so a cut in the wrong place or a missing cut shows up as a nonzero byte or a stray flag. Random operands in all four lane sizes and in both the add and subtract directions check the sums against a model that does whole-lane integer arithmetic. Equal operands under subtraction and zero minus one check the per-lane carry injection and the no-borrow flag. Gaps in the valid stream check the one-cycle latency and that the outputs hold their values between requests.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    localparam int SEG_W  = 8;
    localparam int DATA_W = 256;
    localparam int NUM_SEG = DATA_W / SEG_W;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        LANE_B8  = 2'b00,
        LANE_B16 = 2'b01,
        LANE_B32 = 2'b10,
        LANE_B64 = 2'b11
    } lane_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0]  sum;
        logic [NUM_SEG-1:0] carry;
    } add_result_t;

    // Number of byte segments that make up one lane in the given mode.
    function automatic int lane_segs(lane_mode_e mode);
        return 1 << int'(mode);
    endfunction

endpackage

// File: rtl/lane_boundary_decode.sv
module lane_boundary_decode
    import simd_add_pkg::*;
#(
    parameter int NSEG = NUM_SEG
) (
    input  lane_mode_e        mode,
    output logic [NSEG-1:0]   seg_first,
    output logic [NSEG-1:0]   seg_last
);

    logic [7:0] pos_mask;

    always_comb begin
        pos_mask = 8'(lane_segs(mode) - 1);
    end

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam logic [7:0] KIDX = 8'(k);
        always_comb begin
            seg_first[k] = ((KIDX & pos_mask) == 8'd0);
            seg_last[k]  = ((KIDX & pos_mask) == pos_mask);
        end
    end

endmodule

// File: rtl/byte_seg_add.sv
module byte_seg_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
    end

endmodule

// File: rtl/seg_carry_chain.sv
module seg_carry_chain #(
    parameter int DW = 256,
    parameter int SW = 8,
    localparam int NSEG = DW / SW
) (
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    input  logic            sub,
    input  logic [NSEG-1:0] seg_first,
    input  logic [NSEG-1:0] seg_last,
    output logic [DW-1:0]   sum,
    output logic [NSEG-1:0] flags
);

    logic [NSEG-1:0] cin;
    logic [NSEG-1:0] cout;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        logic [SW-1:0] b_eff;

        always_comb begin
            b_eff = sub ? ~op_b[k*SW +: SW] : op_b[k*SW +: SW];
        end

        if (k == 0) begin : g_low
            always_comb cin[k] = sub;
        end else begin : g_link
            // A lane start cuts the chain and injects the subtract carry.
            always_comb cin[k] = seg_first[k] ? sub : cout[k-1];
        end

        byte_seg_add #(.W(SW)) u_seg (
            .a    (op_a[k*SW +: SW]),
            .b    (b_eff),
            .cin  (cin[k]),
            .sum  (sum[k*SW +: SW]),
            .cout (cout[k])
        );

        always_comb flags[k] = seg_last[k] & cout[k];
    end

endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
    import simd_add_pkg::*;
#(
    parameter int DATA_W = simd_add_pkg::DATA_W,
    parameter int SEG_W  = simd_add_pkg::SEG_W,
    localparam int NSEG  = DATA_W / SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [1:0]        lane_sel,
    input  logic              sub_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sum,
    output logic [NSEG-1:0]   out_carry
);

    lane_mode_e       mode;
    logic [NSEG-1:0]  seg_first;
    logic [NSEG-1:0]  seg_last;
    logic [DATA_W-1:0] comb_sum;
    logic [NSEG-1:0]  comb_flags;

    logic              vld_q;
    logic [DATA_W-1:0] sum_q;
    logic [NSEG-1:0]   carry_q;

    always_comb mode = lane_mode_e'(lane_sel);

    lane_boundary_decode #(.NSEG(NSEG)) u_decode (
        .mode      (mode),
        .seg_first (seg_first),
        .seg_last  (seg_last)
    );

    seg_carry_chain #(.DW(DATA_W), .SW(SEG_W)) u_chain (
        .op_a      (in_a),
        .op_b      (in_b),
        .sub       (sub_en),
        .seg_first (seg_first),
        .seg_last  (seg_last),
        .sum       (comb_sum),
        .flags     (comb_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            sum_q   <= '0;
            carry_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                sum_q   <= comb_sum;
                carry_q <= comb_flags;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_sum   = sum_q;
    assign out_carry = carry_q;

endmodule

// File: rtl/simd_part_adder_chk.sv
module simd_part_adder_chk #(
    parameter int DATA_W = 256,
    parameter int SEG_W  = 8,
    localparam int NSEG  = DATA_W / SEG_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [1:0]        lane_sel,
    input logic              sub_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sum,
    input logic [NSEG-1:0]   out_carry
);

    function automatic logic [NSEG-1:0] top_mask(input logic [1:0] sel);
        logic [NSEG-1:0] m;
        int lb;
        lb = 1 << sel;
        m = '0;
        for (int k = lb - 1; k < NSEG; k += lb) m[k] = 1'b1;
        return m;
    endfunction

    logic [NSEG-1:0] allowed;
    always_comb allowed = top_mask(lane_sel);

    // R10: reset clears the outputs
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sum == '0 && out_carry == '0));

    // R8: valid follows with one cycle latency
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: outputs hold while idle
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sum) && $stable(out_carry)));

    // R7: flags only on lane top bytes
    p_flag_place_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_carry & ~$past(allowed)) == '0));

    // R1: lowest byte in byte mode
    p_byte0_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sub_en && lane_sel == 2'b00) |=>
        (out_sum[SEG_W-1:0] == $past(in_a[SEG_W-1:0] + in_b[SEG_W-1:0])));

    // R6: equal operands subtract to zero with every lane reporting no borrow
    p_sub_equal_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sub_en && in_a == in_b) |=>
        (out_sum == '0 && out_carry == $past(allowed)));

endmodule

bind simd_part_adder simd_part_adder_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .lane_sel  (lane_sel),
    .sub_en    (sub_en),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_carry (out_carry)
);

// File: tb/test_simd_part_adder.sv
module test_simd_part_adder;

    localparam int DW   = 256;
    localparam int NSEG = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [DW-1:0]  in_a = '0;
    logic [DW-1:0]  in_b = '0;
    logic [1:0]     lane_sel = 2'b00;
    logic           sub_en = 1'b0;
    logic           out_valid;
    logic [DW-1:0]  out_sum;
    logic [NSEG-1:0] out_carry;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0]   q_sum[$];
    logic [NSEG-1:0] q_fl[$];
    string           q_tag[$];

    always #4 clk = ~clk;

    simd_part_adder i_simd_part_adder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .lane_sel(lane_sel), .sub_en(sub_en), .out_valid(out_valid),
        .out_sum(out_sum), .out_carry(out_carry)
    );

    // Whole-lane integer model: each lane is lifted into a 65-bit value.
    task automatic model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [1:0] sel, input logic sub,
                         output logic [DW-1:0] s, output logic [NSEG-1:0] f);
        int lbits = 8 << sel;
        int nl = DW / lbits;
        s = '0;
        f = '0;
        for (int l = 0; l < nl; l++) begin
            logic [64:0] x, y, r, mask;
            mask = (65'd1 << lbits) - 65'd1;
            x = '0;
            y = '0;
            for (int i = 0; i < lbits; i++) begin
                x[i] = a[l*lbits + i];
                y[i] = b[l*lbits + i];
            end
            if (sub) y = (~y) & mask;
            r = x + y + {64'd0, sub};
            for (int i = 0; i < lbits; i++) s[l*lbits + i] = r[i];
            f[(l+1)*(lbits/8) - 1] = r[lbits];
        end
    endtask

    function automatic logic [DW-1:0] rnd256();
        logic [DW-1:0] r;
        for (int i = 0; i < DW/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic string mode_tag(input logic [1:0] sel, input logic sub);
        string t;
        case (sel)
            2'b00:   t = "R1/R5/R7";
            2'b01:   t = "R2/R5/R7";
            2'b10:   t = "R3/R5/R7";
            default: t = "R4/R5/R7";
        endcase
        if (sub) t = {t, "/R6"};
        return t;
    endfunction

    // Driver: called just after a rising edge, holds the request for one edge.
    task automatic send(input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [1:0] sel, input logic sub);
        logic [DW-1:0]   es;
        logic [NSEG-1:0] ef;
        model(a, b, sel, sub, es, ef);
        q_sum.push_back(es);
        q_fl.push_back(ef);
        q_tag.push_back(mode_tag(sel, sub));
        in_a = a; in_b = b; lane_sel = sel; sub_en = sub; in_valid = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_a = rnd256(); in_b = rnd256(); lane_sel = 2'($urandom); sub_en = 1'($urandom);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Monitor: samples on the falling edge, away from the register update.
    logic            prev_vld = 1'b0;
    logic            seen = 1'b0;
    logic [DW-1:0]   last_sum = '0;
    logic [NSEG-1:0] last_fl = '0;

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (out_valid !== prev_vld) begin
                fails++;
                $display("FAIL R8 out_valid actual %0b expected %0b", out_valid, prev_vld);
            end
            if (out_valid) begin
                if (q_sum.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected result actual valid expected none");
                end else begin
                    logic [DW-1:0]   es;
                    logic [NSEG-1:0] ef;
                    string t;
                    es = q_sum.pop_front();
                    ef = q_fl.pop_front();
                    t  = q_tag.pop_front();
                    checks++;
                    if (out_sum !== es || out_carry !== ef) begin
                        fails++;
                        $display("FAIL %s actual sum %h carry %h expected sum %h carry %h",
                                 t, out_sum, out_carry, es, ef);
                    end
                    last_sum = es;
                    last_fl  = ef;
                    seen = 1'b1;
                end
            end else if (seen) begin
                checks++;
                if (out_sum !== last_sum || out_carry !== last_fl) begin
                    fails++;
                    $display("FAIL R9 held actual sum %h carry %h expected sum %h carry %h",
                             out_sum, out_carry, last_sum, last_fl);
                end
            end
            prev_vld = in_valid;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sum !== '0 || out_carry !== '0) begin
            fails++;
            $display("FAIL R10 reset actual valid %0b sum %h carry %h expected 0 0 0",
                     out_valid, out_sum, out_carry);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        idle(2);

        // Full ripple: all ones plus one in each lane size (R1..R4, R7)
        for (int m = 0; m < 4; m++) send({DW{1'b1}}, {{(DW-1){1'b0}}, 1'b1}, 2'(m), 1'b0);
        for (int m = 0; m < 4; m++) begin
            logic [DW-1:0] ones_each;
            int lb = 8 << m;
            ones_each = '0;
            for (int l = 0; l < DW / lb; l++) ones_each[l*lb] = 1'b1;
            send({DW{1'b1}}, ones_each, 2'(m), 1'b0);
        end
        idle(3);

        // R6: equal operands, zero minus one
        for (int m = 0; m < 4; m++) begin
            logic [DW-1:0] v;
            v = rnd256();
            send(v, v, 2'(m), 1'b1);
            send('0, {{(DW-1){1'b0}}, 1'b1}, 2'(m), 1'b1);
        end
        idle(1);

        // Random operands in every mode and direction, with gaps
        for (int i = 0; i < 120; i++) begin
            send(rnd256(), rnd256(), 2'(i % 4), 1'((i / 4) % 2));
            if (i % 9 == 0) idle(1 + i % 3);
        end
        idle(4);

        if (q_sum.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R8 results missing actual %0d expected 0", q_sum.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule